// File: doc/BRIEF.md
# Four-State Serial Moore Sequencer

This block is a small clocked Moore machine that walks through four states, encoded as two bits, in response to a serial input bit. The machine moves only on clock edges where the input-valid strobe is high. On those edges, the present state and the data bit pick the next state from a fixed, irregular transition table. The single output bit is decoded from the registered state alone, so it changes only after a clock edge and never follows the data bit within a cycle.

A parent block drives the data bit together with the strobe, and reads the output bit and, where it needs to, the present state. A synchronous, active-high reset returns the machine to state 00.

Top module: `quad_state_seq`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_o` is 2'b00 after that edge, whatever `step_vld` and `din` are.
- R2: `dout` is 1 while `state_o` is 2'b00 or 2'b11, and 0 while `state_o` is 2'b01 or 2'b10.
- R3: From state 2'b00, an accepted step with `din`=0 leads to 2'b01, and one with `din`=1 leads to 2'b10.
- R4: From state 2'b01, an accepted step with `din`=0 leads to 2'b10, and one with `din`=1 leads to 2'b11.
- R5: From state 2'b10, an accepted step with `din`=0 leads to 2'b11, and one with `din`=1 leads to 2'b01.
- R6: From state 2'b11, an accepted step leads to 2'b00 for either value of `din`.
- R7: A step is accepted only at a rising edge with `step_vld` high and `rst` low. At any other edge without reset the state holds, and `din` has no effect on it.
- R8: `dout` does not depend on `din` within a cycle. While the state does not change, toggling `din` leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state 2'b00 |
| step_vld | input | 1 | Accept `din` and advance the state on this edge |
| din | input | 1 | Serial data bit |
| dout | output | 1 | Moore output decoded from the state |
| state_o | output | 2 | Present state, for observation |

## Verification
The bench drives every one of the eight table entries explicitly, including both inputs from 2'b11. A design that let state 11 branch on the input, or that swapped the two arcs out of 10, diverges from the model there.

Long stretches with the strobe low and the data bit changing catch a design that advances without a valid step. A reset asserted in the middle of a run, together with a strobe, catches a design that gives the step priority over reset.

The bench also toggles the data bit several times inside a single cycle while the state is held. A Mealy-style leak from the input into the output would show up as a changing output bit during that window.

// File: rtl/qss_pkg.sv
package qss_pkg;

    localparam int QSS_STATE_W = 2;
    localparam int QSS_NUM_ST  = 1 << QSS_STATE_W;

    typedef enum logic [QSS_STATE_W-1:0] {
        ST_ORIGIN = 2'b00,
        ST_LEFT   = 2'b01,
        ST_RIGHT  = 2'b10,
        ST_APEX   = 2'b11
    } qss_state_e;

    typedef struct packed {
        qss_state_e st;
    } qss_regs_t;

endpackage

// File: rtl/qss_next.sv
module qss_next
    import qss_pkg::*;
(
    input  qss_state_e cur_st,
    input  logic       bit_in,
    output qss_state_e nxt_st
);

    always_comb begin
        nxt_st = ST_ORIGIN;
        unique case (cur_st)
            ST_ORIGIN: nxt_st = bit_in ? ST_RIGHT : ST_LEFT;
            ST_LEFT:   nxt_st = bit_in ? ST_APEX  : ST_RIGHT;
            ST_RIGHT:  nxt_st = bit_in ? ST_LEFT  : ST_APEX;
            ST_APEX:   nxt_st = ST_ORIGIN;
            default:   nxt_st = ST_ORIGIN;
        endcase
    end

endmodule

// File: rtl/qss_out.sv
module qss_out #(
    parameter int STATE_W = 2,
    parameter logic [(1<<STATE_W)-1:0] HIGH_SET = 4'b1001
) (
    input  logic [STATE_W-1:0] st,
    output logic               out_bit
);

    localparam int NUM_ST = 1 << STATE_W;

    logic [NUM_ST-1:0] hit;

    for (genvar g = 0; g < NUM_ST; g++) begin : g_dec
        assign hit[g] = (st == STATE_W'(g)) && HIGH_SET[g];
    end

    assign out_bit = |hit;

endmodule

// File: rtl/quad_state_seq.sv
module quad_state_seq
    import qss_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_vld,
    input  logic                   din,
    output logic                   dout,
    output logic [QSS_STATE_W-1:0] state_o
);

    qss_regs_t  regs_d;
    qss_regs_t  regs_q;
    qss_state_e table_nxt;

    qss_next u_next (
        .cur_st (regs_q.st),
        .bit_in (din),
        .nxt_st (table_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.st = ST_ORIGIN;
        end else if (step_vld) begin
            regs_d.st = table_nxt;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    qss_out #(
        .STATE_W  (QSS_STATE_W),
        .HIGH_SET (4'b1001)
    ) u_out (
        .st      (regs_q.st),
        .out_bit (dout)
    );

    assign state_o = regs_q.st;

endmodule

// File: rtl/qss_checker.sv
module qss_checker (
    input logic       clk,
    input logic       rst,
    input logic       step_vld,
    input logic       din,
    input logic       dout,
    input logic [1:0] state_o
);

    AST_RESET_ORIGIN: assert property (@(posedge clk)
        rst |=> state_o == 2'b00); // R1

    AST_OUT_DECODE: assert property (@(posedge clk) disable iff (rst)
        dout == (state_o == 2'b00 || state_o == 2'b11)); // R2

    AST_FROM_00: assert property (@(posedge clk) disable iff (rst)
        (step_vld && state_o == 2'b00) |=> state_o == ($past(din) ? 2'b10 : 2'b01)); // R3

    AST_FROM_01: assert property (@(posedge clk) disable iff (rst)
        (step_vld && state_o == 2'b01) |=> state_o == ($past(din) ? 2'b11 : 2'b10)); // R4

    AST_FROM_10: assert property (@(posedge clk) disable iff (rst)
        (step_vld && state_o == 2'b10) |=> state_o == ($past(din) ? 2'b01 : 2'b11)); // R5

    AST_FROM_11: assert property (@(posedge clk) disable iff (rst)
        (step_vld && state_o == 2'b11) |=> state_o == 2'b00); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step_vld |=> $stable(state_o)); // R7

    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (rst)
        $stable(state_o) |-> $stable(dout)); // R8

endmodule

bind quad_state_seq qss_checker u_chk (.*);

// File: tb/quad_state_seq_bench.sv
`timescale 1ns/1ps
module quad_state_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_vld = 1'b0;
    logic       din = 1'b0;
    logic       dout;
    logic [1:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    int ref_st = 0;
    bit done = 1'b0;
    int nxt_tab [8];
    logic [7:0] lf = 8'hA5;

    always #4 clk = ~clk;

    quad_state_seq u_quad_state_seq (
        .clk      (clk),
        .rst      (rst),
        .step_vld (step_vld),
        .din      (din),
        .dout     (dout),
        .state_o  (state_o)
    );

    function automatic logic exp_out(input int s);
        return (s == 0) || (s == 3);
    endfunction

    task automatic compare(input string tag);
        n_chk++;
        if (state_o !== 2'(ref_st)) begin
            n_bad++;
            $display("FAIL %s: state actual %b expected %b", tag, state_o, 2'(ref_st));
        end
        n_chk++;
        if (dout !== exp_out(ref_st)) begin
            n_bad++;
            $display("FAIL R2: dout actual %b expected %b (state %0d)", dout, exp_out(ref_st), ref_st);
        end
    endtask

    task automatic cyc(input logic r, input logic v, input logic d);
        string tg;
        @(negedge clk);
        rst = r; step_vld = v; din = d;
        @(posedge clk);
        if (r) tg = "R1";
        else if (!v) tg = "R7";
        else begin
            case (ref_st)
                0: tg = "R3";
                1: tg = "R4";
                2: tg = "R5";
                default: tg = "R6";
            endcase
        end
        if (r) ref_st = 0;
        else if (v) ref_st = nxt_tab[ref_st*2 + int'(d)];
        #1;
        compare(tg);
    endtask

    task automatic go_to(input int target);
        for (int k = 0; k < 8 && ref_st != target; k++) begin
            cyc(1'b0, 1'b1, (ref_st == 0 && target == 2) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic wiggle();
        @(negedge clk);
        rst = 1'b0; step_vld = 1'b0;
        for (int k = 0; k < 3; k++) begin
            din = ~din;
            #1;
            n_chk++;
            if (dout !== exp_out(ref_st)) begin
                n_bad++;
                $display("FAIL R8: dout actual %b expected %b after din toggle", dout, exp_out(ref_st));
            end
        end
        @(posedge clk);
        #1;
        compare("R7");
    endtask

    initial begin
        nxt_tab = '{1, 2, 2, 3, 3, 1, 0, 0};
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);      // R1 reset wins over a step
        // every table entry: R3 R4 R5 R6
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                go_to(s);
                cyc(1'b0, 1'b1, 1'(b));
            end
        end
        // R7 hold with din moving, R8 toggles inside a cycle
        for (int s = 0; s < 4; s++) begin
            go_to(s);
            cyc(1'b0, 1'b0, 1'b1);
            cyc(1'b0, 1'b0, 1'b0);
            wiggle();
        end
        // pseudo-random traffic with occasional reset
        for (int k = 0; k < 400; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cyc((lf[7:3] == 5'd0), lf[0] | lf[2], lf[1]);
        end
        go_to(3);
        cyc(1'b1, 1'b1, 1'b0);      // R1 mid-run reset from 11
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule